// File: doc/BRIEF.md
# Frame Line Pixel Unpacker

This block turns a frame buffer held in memory into a stream of pixels for one frame. It issues byte addresses for 32-bit fetches. It takes the returned words in the order it asked for them and cuts each word into pixels of 1, 2, 4, 8, 16 or 32 bits. Palettized depths yield an 8-bit colour index for a later lookup stage. Direct-colour depths pass the pixel bits through, with an optional swap of the red and blue fields.

A frame begins on a `frame_start` pulse, but only while both the enable and the power controls are high. Each row starts one line stride after the previous one, and the stride follows from the pixel count per row and the depth. A column counter and a row counter mark the last pixel of every row and of the frame. Two ordering options change how a word is split: reversed byte order, and most-significant-first pixels inside each byte.

The configuration is expected to stay unchanged while a frame runs. The row width must make one line a whole number of 32-bit words.

Top module: `fb_line_unpacker`

## Requirements
- R1: While `cfg_enable` or `cfg_power` is low, `req_valid` and `pix_valid` stay low. A `frame_start` pulse seen in that state is dropped and does not begin a frame later.
- R2: Depth codes are 0=1 bit, 1=2 bits, 2=4 bits, 3=8 bits, 4=16 bits and 5=32 bits per pixel. The line stride in bytes is cols/8, cols/4, cols/2, cols, cols*2 or cols*4 for these codes. Requests are byte addresses `cfg_base + row*stride + 4*k`, with exactly rows*stride/4 requests per frame.
- R3: With both ordering options off, pixel j of a word with B bits per pixel is bits [j*B +: B], so the least significant bits hold the first pixel.
- R4: With only `cfg_be_pix` set, bytes are still taken from byte 0 upward. Within a byte, sub-byte pixels are taken from bit 7 downward. At 8, 16 and 32 bits this option changes nothing.
- R5: With `cfg_be_byte` set, the word is byte-reversed and pixels are taken from its most significant end. When both ordering options are set, this byte-reversed order applies.
- R6: Depths 0 to 3 give the pixel value zero-extended, so `pix_data[31:8]` is 0. Depth 4 gives 16 bits in `pix_data[15:0]` with the upper half 0. Depth 5 gives all 32 bits.
- R7: With `cfg_bgr` set, a 16-bit pixel has bits [15:11] and [4:0] exchanged, and a 32-bit pixel has bytes [23:16] and [7:0] exchanged. The setting has no effect on depths 0 to 3.
- R8: `pix_eol` is high with the last pixel of every row. `pix_eof` is high with the last pixel of the frame, together with `pix_eol`.
- R9: After `cfg_rows` rows have been delivered, no further pixels or requests appear until a new accepted `frame_start`.
- R10: While `pix_valid` is high and `pix_ready` is low, the pixel and its flags hold. While `req_valid` is high and `req_ready` is low, the address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Display enable control |
| cfg_power | input | 1 | Panel power control |
| cfg_depth | input | 3 | Depth code, 0..5 |
| cfg_be_byte | input | 1 | Byte-reversed word order |
| cfg_be_pix | input | 1 | Most-significant-first pixels inside each byte |
| cfg_bgr | input | 1 | Swap red and blue fields of direct-colour pixels |
| cfg_base | input | ADDR_W | Byte address of the first row |
| cfg_cols | input | COL_W | Pixels per row |
| cfg_rows | input | ROW_W | Rows per frame |
| frame_start | input | 1 | Pulse that begins a frame |
| req_valid | output | 1 | Fetch address valid |
| req_ready | input | 1 | Fetch address accepted |
| req_addr | output | ADDR_W | Fetch byte address |
| wd_valid | input | 1 | Returned word valid |
| wd_ready | output | 1 | Returned word accepted |
| wd_data | input | 32 | Returned word |
| pix_valid | output | 1 | Pixel valid |
| pix_ready | input | 1 | Pixel accepted |
| pix_data | output | 32 | Palette index or direct-colour pixel |
| pix_eol | output | 1 | Last pixel of a row |
| pix_eof | output | 1 | Last pixel of the frame |

## Verification
The risky coincidence is the hand-over of the last pixel of a word in the same cycle that the next word is taken. When that pixel also closes a row, the row counter and the word refill move together. The bench makes this happen often by running the fetch and pixel sides with different stall patterns, so refills land both on stalled and on accepted row-end pixels. Each pixel's value and flags are compared with a value worked out from its position in the frame. A second case is the frame-end pixel coinciding with an offered word. That case is judged by checking that exactly rows*stride/4 words are taken and that everything stays quiet afterwards.

// File: rtl/fbu_pkg.sv
`timescale 1ns/1ps
package fbu_pkg;

   // log2 of bits per pixel; reserved codes fall back to the widest depth
   function automatic logic [2:0] depth_log2(input logic [2:0] code);
      return (code > 3'd5) ? 3'd5 : code;
   endfunction

   // index of the last pixel inside a 32-bit word
   function automatic logic [4:0] word_last_pix(input logic [2:0] l2);
      return 5'(5'd31 >> l2);
   endfunction

endpackage

// File: rtl/fbu_addr_gen.sv
`timescale 1ns/1ps
module fbu_addr_gen #(
   parameter int ADDR_W = 32,
   parameter int ROW_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              on_i,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] stride_i,
   input  logic [ROW_W-1:0]  rows_i,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr
);
   localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

   logic              busy_q;
   logic [ADDR_W-1:0] row_base_q;
   logic [ADDR_W-1:0] off_q;
   logic [ROW_W-1:0]  row_q;
   logic              fire;
   logic              row_wrap;

   assign req_valid = busy_q && on_i;
   assign req_addr  = row_base_q + off_q;
   assign fire      = req_valid && req_ready;
   assign row_wrap  = (off_q + WORD_BYTES) >= stride_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         row_base_q <= '0;
         off_q      <= '0;
         row_q      <= '0;
      end else if (start_i) begin
         busy_q     <= 1'b1;
         row_base_q <= base_i;
         off_q      <= '0;
         row_q      <= '0;
      end else if (!on_i) begin
         busy_q <= 1'b0;
      end else if (fire) begin
         if (row_wrap) begin
            off_q      <= '0;
            row_base_q <= row_base_q + stride_i;
            row_q      <= row_q + 1'b1;
            if (row_q == rows_i - 1'b1) busy_q <= 1'b0;
         end else begin
            off_q <= off_q + WORD_BYTES;
         end
      end
   end
endmodule

// File: rtl/fbu_pix_extract.sv
`timescale 1ns/1ps
module fbu_pix_extract #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [4:0]        idx_i,
   input  logic [2:0]        l2_i,
   input  logic              be_byte_i,
   input  logic              be_pix_i,
   input  logic              bgr_i,
   output logic [WORD_W-1:0] pix_o
);
   localparam int N_MODES = 6;

   logic [WORD_W-1:0] swapped;
   logic [WORD_W-1:0] src;
   logic [WORD_W-1:0] cand [N_MODES];

   assign swapped = {word_i[7:0], word_i[15:8], word_i[23:16], word_i[31:24]};
   assign src     = be_byte_i ? swapped : word_i;

   for (genvar m = 0; m < N_MODES; m++) begin : g_mode
      localparam int BPP = 1 << m;
      localparam int PPW = WORD_W / BPP;
      localparam logic [4:0] JMASK = 5'(PPW - 1);

      logic [4:0]        j;
      logic [4:0]        pos;
      logic [WORD_W-1:0] sh;

      assign j = idx_i & JMASK;

      if (m < 3) begin : g_sub
         localparam int SH = 3 - m;
         localparam logic [4:0] SMASK = 5'((8 >> m) - 1);
         logic [4:0] sub;
         logic [4:0] bbase;
         assign sub   = j & SMASK;
         assign bbase = 5'((j >> SH) << 3);
         always_comb begin
            if (be_byte_i)     pos = 5'((JMASK - j) << m);
            else if (be_pix_i) pos = 5'(bbase + 5'((SMASK - sub) << m));
            else               pos = 5'(bbase + 5'(sub << m));
         end
      end else begin : g_wide
         always_comb begin
            if (be_byte_i) pos = 5'((JMASK - j) << m);
            else           pos = 5'(j << m);
         end
      end

      assign sh = src >> pos;

      if (m < 4) begin : g_index
         assign cand[m] = WORD_W'(sh[BPP-1:0]);
      end else if (m == 4) begin : g_rgb16
         assign cand[m] = bgr_i ? {16'd0, sh[4:0], sh[10:5], sh[15:11]}
                                : {16'd0, sh[15:0]};
      end else begin : g_rgb32
         assign cand[m] = bgr_i ? {sh[31:24], sh[7:0], sh[15:8], sh[23:16]}
                                : sh;
      end
   end

   always_comb begin
      case (l2_i)
         3'd0:    pix_o = cand[0];
         3'd1:    pix_o = cand[1];
         3'd2:    pix_o = cand[2];
         3'd3:    pix_o = cand[3];
         3'd4:    pix_o = cand[4];
         default: pix_o = cand[5];
      endcase
   end
endmodule

// File: rtl/fbu_pos_count.sv
`timescale 1ns/1ps
module fbu_pos_count #(
   parameter int COL_W = 12,
   parameter int ROW_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             step_i,
   input  logic [COL_W-1:0] cols_i,
   input  logic [ROW_W-1:0] rows_i,
   output logic             eol_o,
   output logic             eof_o
);
   logic [COL_W-1:0] col_q;
   logic [ROW_W-1:0] row_q;

   assign eol_o = (col_q == cols_i - 1'b1);
   assign eof_o = eol_o && (row_q == rows_i - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n || start_i) begin
         col_q <= '0;
         row_q <= '0;
      end else if (step_i) begin
         if (eol_o) begin
            col_q <= '0;
            row_q <= row_q + 1'b1;
         end else begin
            col_q <= col_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/fb_line_unpacker.sv
`timescale 1ns/1ps
module fb_line_unpacker #(
   parameter int ADDR_W = 32,
   parameter int COL_W  = 12,
   parameter int ROW_W  = 11,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic              cfg_power,
   input  logic [2:0]        cfg_depth,
   input  logic              cfg_be_byte,
   input  logic              cfg_be_pix,
   input  logic              cfg_bgr,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [COL_W-1:0]  cfg_cols,
   input  logic [ROW_W-1:0]  cfg_rows,
   input  logic              frame_start,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   input  logic              wd_valid,
   output logic              wd_ready,
   input  logic [WORD_W-1:0] wd_data,
   output logic              pix_valid,
   input  logic              pix_ready,
   output logic [WORD_W-1:0] pix_data,
   output logic              pix_eol,
   output logic              pix_eof
);
   import fbu_pkg::*;

   initial begin
      if (WORD_W != 32) $fatal(1, "fb_line_unpacker: WORD_W must be 32");
      if (ADDR_W < COL_W + 3) $fatal(1, "fb_line_unpacker: ADDR_W too small for stride");
      if (COL_W < 5 || ROW_W < 1) $fatal(1, "fb_line_unpacker: counter widths too small");
   end

   logic              on_ok;
   logic              start_ok;
   logic [2:0]        l2;
   logic [4:0]        last_idx;
   logic [ADDR_W-1:0] cols_ext;
   logic [ADDR_W-1:0] stride;

   logic              run_q;
   logic              have_q;
   logic [WORD_W-1:0] word_q;
   logic [4:0]        idx_q;

   logic pix_fire;
   logic word_done;
   logic wd_fire;

   assign on_ok    = cfg_enable && cfg_power;
   assign start_ok = frame_start && on_ok && !run_q;
   assign l2       = depth_log2(cfg_depth);
   assign last_idx = word_last_pix(l2);
   assign cols_ext = ADDR_W'(cfg_cols);
   assign stride   = (l2 < 3'd3) ? (cols_ext >> (3'd3 - l2)) : (cols_ext << (l2 - 3'd3));

   assign pix_valid = run_q && on_ok && have_q;
   assign pix_fire  = pix_valid && pix_ready;
   assign word_done = pix_fire && (idx_q == last_idx || pix_eof);
   assign wd_ready  = run_q && on_ok && (!have_q || (word_done && !pix_eof));
   assign wd_fire   = wd_valid && wd_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         have_q <= 1'b0;
         word_q <= '0;
         idx_q  <= '0;
      end else if (start_ok) begin
         run_q  <= 1'b1;
         have_q <= 1'b0;
         idx_q  <= '0;
      end else if (!on_ok) begin
         run_q  <= 1'b0;
         have_q <= 1'b0;
      end else begin
         if (pix_fire && pix_eof) run_q <= 1'b0;
         if (wd_fire) begin
            have_q <= 1'b1;
            word_q <= wd_data;
            idx_q  <= '0;
         end else begin
            if (word_done) have_q <= 1'b0;
            if (pix_fire)  idx_q  <= idx_q + 1'b1;
         end
      end
   end

   fbu_addr_gen #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) addr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .on_i      (on_ok),
      .start_i   (start_ok),
      .base_i    (cfg_base),
      .stride_i  (stride),
      .rows_i    (cfg_rows),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_addr  (req_addr)
   );

   fbu_pix_extract #(.WORD_W(WORD_W)) extract_i (
      .word_i    (word_q),
      .idx_i     (idx_q),
      .l2_i      (l2),
      .be_byte_i (cfg_be_byte),
      .be_pix_i  (cfg_be_pix),
      .bgr_i     (cfg_bgr),
      .pix_o     (pix_data)
   );

   fbu_pos_count #(.COL_W(COL_W), .ROW_W(ROW_W)) count_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_ok),
      .step_i  (pix_fire),
      .cols_i  (cfg_cols),
      .rows_i  (cfg_rows),
      .eol_o   (pix_eol),
      .eof_o   (pix_eof)
   );
endmodule

// File: rtl/fbu_chk.sv
`timescale 1ns/1ps
module fbu_chk #(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_enable,
   input logic              cfg_power,
   input logic [2:0]        cfg_depth,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              pix_valid,
   input logic              pix_ready,
   input logic [WORD_W-1:0] pix_data,
   input logic              pix_eol,
   input logic              pix_eof
);
   a_r1_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_enable && cfg_power) |-> (!pix_valid && !req_valid));

   a_r8_eof_has_eol: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_eof) |-> pix_eol);

   a_r6_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && cfg_depth <= 3'd3) |-> (pix_data[WORD_W-1:8] == '0));

   a_r10_pix_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_ready) |=>
         (!(cfg_enable && cfg_power) ||
          (pix_valid && $stable(pix_data) && $stable(pix_eol) && $stable(pix_eof))));

   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=>
         (!(cfg_enable && cfg_power) || (req_valid && $stable(req_addr))));
endmodule

bind fb_line_unpacker fbu_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_enable (cfg_enable),
   .cfg_power  (cfg_power),
   .cfg_depth  (cfg_depth),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_addr   (req_addr),
   .pix_valid  (pix_valid),
   .pix_ready  (pix_ready),
   .pix_data   (pix_data),
   .pix_eol    (pix_eol),
   .pix_eof    (pix_eof)
);

// File: tb/fb_line_unpacker_tb_top.sv
`timescale 1ns/1ps
module fb_line_unpacker_tb_top;
   localparam int ADDR_W = 32;
   localparam int COL_W  = 12;
   localparam int ROW_W  = 11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_enable = 1'b0, cfg_power = 1'b0;
   logic [2:0] cfg_depth = 3'd0;
   logic cfg_be_byte = 1'b0, cfg_be_pix = 1'b0, cfg_bgr = 1'b0;
   logic [ADDR_W-1:0] cfg_base = '0;
   logic [COL_W-1:0]  cfg_cols = 12'd32;
   logic [ROW_W-1:0]  cfg_rows = 11'd1;
   logic frame_start = 1'b0;
   logic req_valid, req_ready = 1'b0;
   logic [ADDR_W-1:0] req_addr;
   logic wd_valid = 1'b0, wd_ready;
   logic [31:0] wd_data = '0;
   logic pix_valid, pix_ready = 1'b0;
   logic [31:0] pix_data;
   logic pix_eol, pix_eof;

   always #2.5 clk = ~clk;

   fb_line_unpacker #(.ADDR_W(ADDR_W), .COL_W(COL_W), .ROW_W(ROW_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_power(cfg_power),
      .cfg_depth(cfg_depth), .cfg_be_byte(cfg_be_byte), .cfg_be_pix(cfg_be_pix),
      .cfg_bgr(cfg_bgr), .cfg_base(cfg_base), .cfg_cols(cfg_cols), .cfg_rows(cfg_rows),
      .frame_start(frame_start), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
      .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
      .pix_eol(pix_eol), .pix_eof(pix_eof)
   );

   int total = 0, bad = 0;
   int cyc = 0;
   int reqs = 0, fed = 0, pcount = 0, quiet_bad = 0;
   int rphase = 0, pphase = 0;
   bit quiet = 1'b0, finished = 1'b0;

   function automatic logic [31:0] mword(input logic [31:0] a);
      return a * 32'h0019660D + 32'h3C6EF35F;
   endfunction

   // expected pixel from the requirement rules, byte by byte
   function automatic logic [31:0] exp_pix(input logic [31:0] w, input int j, input int d,
                                           input bit bb, input bit bp, input bit bgr);
      logic [7:0] b [4];
      int bpp, k, sh;
      logic [31:0] v;
      bpp = 1 << d;
      for (int i = 0; i < 4; i++) b[i] = w[8*i +: 8];
      if (bpp < 8 && (bb || bp)) begin
         k  = (j * bpp) / 8;
         sh = 8 - bpp - ((j * bpp) % 8);
         v  = 32'((b[k] >> sh) & 8'((1 << bpp) - 1));
      end else if (bb && bpp == 16) begin
         v = {16'd0, b[2*j], b[2*j+1]};
      end else if (bb && bpp == 32) begin
         v = {b[0], b[1], b[2], b[3]};
      end else if (bpp == 32) begin
         v = w;
      end else begin
         v = (w >> (j * bpp)) & ((32'd1 << bpp) - 32'd1);
      end
      if (bgr && bpp == 16) v = {16'd0, v[4:0], v[10:5], v[15:11]};
      if (bgr && bpp == 32) v = {v[31:24], v[7:0], v[15:8], v[23:16]};
      return v;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", tag, act, expv, $time);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   int cur_d = 0, cur_cols = 32, cur_total = 0;
   bit cur_bb = 0, cur_bp = 0, cur_bgr = 0;

   task automatic step();
      @(negedge clk);
      cyc++;
      req_ready = ((cyc + rphase) % 3) != 1;
      pix_ready = ((cyc + pphase) % 4) != 3;
      wd_valid  = fed < reqs;
      wd_data   = mword(cfg_base + 32'(4 * fed));
      #1;
      if (quiet && (pix_valid || req_valid)) quiet_bad++;
      if (req_valid && req_ready) begin
         check(req_addr == cfg_base + 32'(4 * reqs), "R2 address", req_addr,
               cfg_base + 32'(4 * reqs));
         reqs++;
      end
      if (wd_valid && wd_ready) fed++;
      if (pix_valid && pix_ready) begin
         int ppw, n, j;
         string tag;
         logic [31:0] e;
         ppw = 32 >> cur_d;
         n = pcount / ppw;
         j = pcount % ppw;
         e = exp_pix(mword(cfg_base + 32'(4 * n)), j, cur_d, cur_bb, cur_bp, cur_bgr);
         if (cur_bb) tag = "R5 pixel";
         else if (cur_bp) tag = "R4 pixel";
         else tag = "R3 pixel";
         if (cur_bgr) tag = {tag, " R7"};
         if (cur_d <= 3) check(pix_data[31:8] == 24'd0, "R6 index width", pix_data, e);
         check(pix_data == e, tag, pix_data, e);
         check(pix_eol == ((pcount % cur_cols) == cur_cols - 1), "R8 eol",
               32'(pix_eol), 32'((pcount % cur_cols) == cur_cols - 1));
         check(pix_eof == (pcount == cur_total - 1), "R8 eof",
               32'(pix_eof), 32'(pcount == cur_total - 1));
         pcount++;
      end
   endtask

   task automatic quiet_window(input int n, input string tag);
      quiet = 1'b1;
      quiet_bad = 0;
      for (int i = 0; i < n; i++) step();
      quiet = 1'b0;
      check(quiet_bad == 0, tag, 32'(quiet_bad), 32'd0);
   endtask

   task automatic run_frame(input int d, input bit bb, input bit bp, input bit bgr,
                            input int cols, input int rows, input logic [31:0] base);
      int stride, words, guard;
      stride = (d < 3) ? (cols >> (3 - d)) : (cols << (d - 3));
      words  = rows * stride / 4;
      cur_d = d; cur_bb = bb; cur_bp = bp; cur_bgr = bgr;
      cur_cols = cols; cur_total = cols * rows;
      reqs = 0; fed = 0; pcount = 0;
      rphase = d + rows; pphase = cols / 32 + (bb ? 1 : 0);
      cfg_depth = 3'(d); cfg_be_byte = bb; cfg_be_pix = bp; cfg_bgr = bgr;
      cfg_cols = COL_W'(cols); cfg_rows = ROW_W'(rows); cfg_base = base;
      frame_start = 1'b1;
      step();
      frame_start = 1'b0;
      guard = 0;
      while (pcount < cur_total && guard < 6000) begin
         step();
         guard++;
      end
      check(pcount == cur_total, "R9 pixel count", 32'(pcount), 32'(cur_total));
      check(reqs == words, "R2 request count", 32'(reqs), 32'(words));
      quiet_window(20, "R9 stop after frame");
   endtask

   initial begin
      #(5.0 * 190000);
      check(1'b0, "watchdog", 32'(cyc), 32'd0);
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(!pix_valid, "reset pix_valid", 32'(pix_valid), 32'd0);
      check(!req_valid, "reset req_valid", 32'(req_valid), 32'd0);
      check(!wd_ready, "reset wd_ready", 32'(wd_ready), 32'd0);

      // R1: start pulses while one control is low
      cfg_enable = 1'b1; cfg_power = 1'b0;
      frame_start = 1'b1; step(); frame_start = 1'b0;
      quiet_window(30, "R1 power low");
      cfg_enable = 1'b0; cfg_power = 1'b1;
      frame_start = 1'b1; step(); frame_start = 1'b0;
      quiet_window(30, "R1 enable low");
      cfg_enable = 1'b1;
      quiet_window(30, "R1 dropped start");

      // sweep depths, orderings and colour swap
      for (int d = 0; d < 6; d++)
         for (int o = 0; o < 4; o++)
            for (int c = 0; c < 2; c++)
               run_frame(d, o[1], o[0], c[0], 32, 3, 32'h0000_1000 + 32'(d * 256 + o * 16));

      // other geometries
      run_frame(2, 1'b0, 1'b1, 1'b0, 64, 1, 32'h0004_0000);
      run_frame(0, 1'b0, 1'b0, 1'b0, 96, 2, 32'h0000_0200);
      run_frame(4, 1'b1, 1'b0, 1'b1, 16, 4, 32'h8000_0000);
      run_frame(5, 1'b0, 1'b0, 1'b0, 8, 5, 32'h0000_0040);
      summary();
   end
endmodule